// File: doc/BRIEF.md
# Radio Register Serial Access Master

This block is a serial peripheral interface master. It runs register transactions against a radio transceiver. A host picks an operation, a 6-bit register address and, for burst operations, a byte count. It then supplies write data one byte at a time over a valid/ready pair. Bytes read back come out one at a time, each marked by a single-cycle valid pulse.

Each transaction starts with chip select going low. The block then holds the serial clock low until the slave pulls MISO low to show it is ready. After that it shifts out a header byte, which carries a read flag, a burst flag and the address. Data bytes follow, in either direction. Chip select goes high again only after the final clock edge. It then stays high for a guard time before the next command is taken. The serial clock rate is the system clock divided by twice the `CLK_DIV` parameter.

Top module: `radio_spi_master`

## Requirements
- R1: Out of reset and between transactions, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_mosi` is 0. `spi_sck` is never high while `spi_cs_n` is high.
- R2: After `spi_cs_n` falls, no rising edge of `spi_sck` occurs while `spi_miso` is high. The header starts only after `spi_miso` is seen low.
- R3: The header byte is {read flag, burst flag, addr[5:0]}, with the read flag in bit 7 and the burst flag in bit 6. The `cmd_op` codes are: 0 single write {0,0}, 1 burst write {0,1}, 2 single read {1,0}, 3 burst read {1,1}, 4 status read {1,1}, 5 (also 6 and 7) command strobe {0,0}.
- R4: Every byte goes out most significant bit first. `spi_mosi` changes only while `spi_sck` is low, so it is stable over each high phase.
- R5: A single write (op 0) sends the header, then one byte taken from `tx_data`, under a single chip select assertion. That is 16 SCK pulses.
- R6: A burst write (op 1) sends the header, then `cmd_count` bytes from the byte interface in order. A count of 0 sends the header only.
- R7: A single read (op 2) sends the header, then clocks in one byte. MISO is sampled during the high phase and shifted into the LSB. The byte is given on `rx_data` with a one-cycle `rx_valid` pulse.
- R8: A burst read (op 3) clocks in `cmd_count` bytes under one chip select assertion. Each byte gets its own `rx_valid` pulse, in arrival order.
- R9: A status read (op 4) uses the read-plus-burst header and returns exactly one byte, whatever `cmd_count` is.
- R10: A command strobe (op 5) sends only the header byte, which is 8 SCK pulses, and then releases chip select.
- R11: `busy` is high from the cycle after a command is accepted until chip select rises. `cmd_ready` is low throughout that time.
- R12: Between two transactions, chip select stays high for at least `CLK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 3 | Operation code (see R3) |
| cmd_addr | input | 6 | Register address |
| cmd_count | input | CNT_W | Byte count for burst operations |
| tx_valid | input | 1 | Write data byte available |
| tx_ready | output | 1 | Write data byte taken when high together with tx_valid |
| tx_data | input | 8 | Write data byte |
| rx_valid | output | 1 | One-cycle pulse marking a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave; low means ready after select |

## Verification
Every result has a known cycle position once MISO is seen low:
- The first SCK rise follows `CLK_DIV` cycles later.
- Each bit then takes `2*CLK_DIV` cycles.
- `rx_valid` comes out in the cycle after the falling edge that ends a byte.
- Chip select rises `CLK_DIV` cycles after the last falling edge.

The bench avoids counting cycles for data. It captures MOSI on each SCK rise and drives MISO from a count of SCK falls. It samples `rx_valid`, `busy`, `cmd_ready` and chip select on the falling clock edge, so each single-cycle pulse is seen exactly once. It measures the high time of chip select in clock cycles.

// File: rtl/radio_spi_master.sv
module radio_spi_master #(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [5:0]       cmd_addr,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SHIFT, S_FETCH, S_END, S_HOLD} state_t;
  state_t state;

  logic [DIV_W-1:0] div;
  logic [7:0]       sh, rx;
  logic [2:0]       bitn;
  logic [CNT_W-1:0] left;
  logic             rd_q, hdr_phase, sck_q, cs_q;

  logic             op_rd, op_burst, op_strobe;
  logic [7:0]       hdr;
  logic [CNT_W-1:0] nbytes, remain;
  logic             div_end;

  assign op_strobe = cmd_op >= 3'd5;
  assign op_rd     = (cmd_op == 3'd2) || (cmd_op == 3'd3) || (cmd_op == 3'd4);
  assign op_burst  = (cmd_op == 3'd1) || (cmd_op == 3'd3) || (cmd_op == 3'd4);
  assign hdr       = {op_rd, op_burst, cmd_addr};
  assign nbytes    = op_strobe ? '0 :
                     ((cmd_op == 3'd1) || (cmd_op == 3'd3)) ? cmd_count : CNT_W'(1);
  assign remain    = hdr_phase ? left : left - CNT_W'(1);
  assign div_end   = div == DIV_LAST;

  assign cmd_ready = state == S_IDLE;
  assign tx_ready  = state == S_FETCH;
  assign busy      = (state != S_IDLE) && (state != S_HOLD);
  assign spi_cs_n  = cs_q;
  assign spi_sck   = sck_q;
  assign spi_mosi  = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      div       <= '0;
      sh        <= '0;
      rx        <= '0;
      bitn      <= '0;
      left      <= '0;
      rd_q      <= 1'b0;
      hdr_phase <= 1'b0;
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          cs_q  <= 1'b0;
          sh    <= hdr;
          rd_q  <= op_rd;
          left  <= nbytes;
          state <= S_WAIT;
        end
        S_WAIT: if (!spi_miso) begin
          div       <= '0;
          bitn      <= '0;
          hdr_phase <= 1'b1;
          state     <= S_SHIFT;
        end
        S_SHIFT: begin
          if (!div_end) begin
            div <= div + 1'b1;
          end else begin
            div <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
            end else begin
              sck_q <= 1'b0;
              sh    <= {sh[6:0], 1'b0};
              rx    <= {rx[6:0], spi_miso};
              bitn  <= bitn + 1'b1;
              if (bitn == 3'd7) begin
                if (!hdr_phase && rd_q) begin
                  rx_valid <= 1'b1;
                  rx_data  <= {rx[6:0], spi_miso};
                end
                hdr_phase <= 1'b0;
                left      <= remain;
                if (remain == '0) state <= S_END;
                else if (!rd_q)   state <= S_FETCH;
              end
            end
          end
        end
        S_FETCH: if (tx_valid) begin
          sh    <= tx_data;
          div   <= '0;
          state <= S_SHIFT;
        end
        S_END: begin
          div <= div_end ? '0 : div + 1'b1;
          if (div_end) begin
            cs_q  <= 1'b1;
            state <= S_HOLD;
          end
        end
        S_HOLD: begin
          div <= div_end ? '0 : div + 1'b1;
          if (div_end) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  cs_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |=> !$rose(spi_sck));

  // R11
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> (busy && !cmd_ready));

  // R12
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !cmd_ready);

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: tb/radio_spi_master_bench.sv
`timescale 1ns/1ps
module radio_spi_master_bench;
  localparam int CLK_DIV = 2;
  localparam int CNT_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [5:0] cmd_addr = '0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic cmd_ready, tx_ready, rx_valid, busy, spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  int busy_len = 0;
  logic miso_hold = 1'b0;
  int nrise = 0, nfall = 0, nrx = 0, sck_busy = 0, ready_in_busy = 0;
  int hi_run = 0, last_gap = 0;
  logic bits [0:511];
  logic [7:0] rxs [0:63];

  always #2.5 clk = ~clk;

  radio_spi_master #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_radio_spi_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  function automatic logic [7:0] rdbyte(int j);
    return 8'(8'h3C + j * 8'h29);
  endfunction
  function automatic logic [7:0] wrbyte(int j);
    return 8'(8'hC3 ^ (j * 8'h17));
  endfunction
  function automatic logic sbit(int k);
    logic [7:0] b;
    if (k < 8) return 1'b0;
    b = rdbyte(k / 8 - 1);
    return b[7 - (k % 8)];
  endfunction
  function automatic logic [7:0] hdr_of(int op, logic [5:0] a);
    logic r, bu;
    r  = (op == 2) || (op == 3) || (op == 4);
    bu = (op == 1) || (op == 3) || (op == 4);
    return {r, bu, a};
  endfunction
  function automatic logic [7:0] sent(int j);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7-i] = bits[8*j + i];
    return v;
  endfunction

  assign spi_miso = spi_cs_n ? 1'b1 : (miso_hold ? 1'b1 : sbit(nfall));

  initial forever begin
    @(negedge spi_cs_n);
    miso_hold = 1'b1;
    repeat (busy_len) @(posedge clk);
    #1 miso_hold = 1'b0;
  end

  always @(posedge spi_sck) begin
    if (nrise < 512) bits[nrise] = spi_mosi;
    nrise++;
    if (miso_hold) sck_busy++;
  end
  always @(negedge spi_sck) nfall++;

  always @(negedge clk) begin
    if (rx_valid) begin
      if (nrx < 64) rxs[nrx] = rx_data;
      nrx++;
    end
    if (busy && cmd_ready) ready_in_busy++;
    if (spi_cs_n) hi_run++;
    else begin
      if (hi_run != 0) last_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(int op, logic [5:0] a, int n, int blen);
    int nfeed;
    busy_len = blen;
    nrise = 0; nfall = 0; nrx = 0; sck_busy = 0; ready_in_busy = 0;
    nfeed = (op == 0) ? 1 : (op == 1) ? n : 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_count = CNT_W'(n);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    fork
      begin
        for (int i = 0; i < nfeed; i++) begin
          tx_valid = 1'b1; tx_data = wrbyte(i);
          while (!tx_ready) @(negedge clk);
          @(negedge clk);
          tx_valid = 1'b0;
        end
      end
      begin
        while (busy) @(negedge clk);
      end
    join
  endtask

  task automatic t_reset;
    chk("R1 cs idle", spi_cs_n, 1);
    chk("R1 sck idle", spi_sck, 0);
    chk("R1 mosi idle", spi_mosi, 0);
    chk("R11 ready idle", cmd_ready, 1);
  endtask

  task automatic t_single_write;
    run(0, 6'h0D, 0, 3);
    chk("R3 write header", sent(0), hdr_of(0, 6'h0D));
    chk("R5 write data MSB first", sent(1), wrbyte(0));
    chk("R5 pulse count", nrise, 16);
    chk("R1 cs after", spi_cs_n, 1);
    chk("R11 ready low while busy", ready_in_busy, 0);
  endtask

  task automatic t_burst_write;
    run(1, 6'h3F, 3, 1);
    chk("R3 burst write header", sent(0), hdr_of(1, 6'h3F));
    for (int j = 0; j < 3; j++) chk("R6 burst byte", sent(j + 1), wrbyte(j));
    chk("R6 pulse count", nrise, 32);
    run(1, 6'h05, 0, 0);
    chk("R6 count zero header only", nrise, 8);
  endtask

  task automatic t_single_read;
    run(2, 6'h21, 5, 2);
    chk("R3 read header", sent(0), hdr_of(2, 6'h21));
    chk("R7 one byte", nrx, 1);
    chk("R7 read value", rxs[0], rdbyte(0));
    chk("R7 pulse count", nrise, 16);
  endtask

  task automatic t_burst_read;
    run(3, 6'h12, 4, 2);
    chk("R3 burst read header", sent(0), hdr_of(3, 6'h12));
    chk("R8 byte count", nrx, 4);
    for (int j = 0; j < 4; j++) chk("R8 burst value", rxs[j], rdbyte(j));
    chk("R8 mosi zero during read", sent(2), 0);
  endtask

  task automatic t_status;
    run(4, 6'h3B, 7, 2);
    chk("R9 status header", sent(0), 8'hFB);
    chk("R9 one byte", nrx, 1);
    chk("R9 value", rxs[0], rdbyte(0));
  endtask

  task automatic t_strobe;
    run(5, 6'h36, 3, 2);
    chk("R10 strobe header", sent(0), 8'h36);
    chk("R10 pulse count", nrise, 8);
    chk("R10 no rx", nrx, 0);
  endtask

  task automatic t_ready_wait;
    run(2, 6'h01, 0, 25);
    chk("R2 no sck while miso high", sck_busy, 0);
    chk("R2 header intact", sent(0), 8'h81);
    chk("R2 data intact", rxs[0], rdbyte(0));
  endtask

  task automatic t_back_to_back;
    run(5, 6'h30, 0, 0);
    run(5, 6'h31, 0, 0);
    chk("R12 cs gap", (last_gap >= CLK_DIV) ? 1 : 0, 1);
    chk("R10 second strobe", sent(0), 8'h31);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_burst_write();
    t_single_read();
    t_burst_read();
    t_status();
    t_strobe();
    t_ready_wait();
    t_back_to_back();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule